// File: doc/BRIEF.md
# Issue-Aware Warp Fetch Arbiter

This block sits in the front end of a SIMT core. It decides which warp may send a request to the instruction cache in a given cycle, and it tracks the small instruction buffer each warp owns. Each warp has a fixed number of buffer slots. Every slot carries two bits: one that says an instruction is present, and one that says that instruction is ready to execute. A warp can compete for a fetch only when its buffer is completely empty and it has no fetch already in flight.

By default, competing warps are served in rotation. When the critical-first mode pin is high, the block takes a hint from the issue scheduler: the warp that scheduler expects to issue in the next cycle. If that warp can compete, it wins the fetch. This keeps fetch order in step with issue order. If the hinted warp cannot compete, the block falls back to rotation. Issue events empty slots. Fetch responses fill them.

The fetch grant is a valid/ready stream toward the instruction cache. `fetch_vld` offers `fetch_warp`, and the grant takes effect only in a cycle where `fetch_rdy` is also high. While `fetch_rdy` is low, no state changes. The offered warp is recomputed every cycle from the current state and the mode and hint pins, so it may change before it is accepted. Fill and issue events are single-cycle strobes with no back-pressure.

Top module: `warp_fetch_arbiter`

## Requirements
- R1: After reset, every slot valid bit and ready bit is 0, no warp has a fetch in flight, and the rotation search starts at warp 0.
- R2: A warp is offered on `fetch_warp` only if none of its slots is valid and no fetch it was granted is still awaiting its fill. Slot `s` of warp `w` is bit `w*SLOTS+s` of `slot_valid` and `slot_ready`.
- R3: In rotation, the search starts at the warp after the last accepted rotation grant, wraps past the highest warp to warp 0, and skips warps that cannot compete.
- R4: When `crit_mode` is 1 and `pred_vld` is 1, and warp `pred_warp` can compete, that warp is offered ahead of all others.
- R5: When `crit_mode` is 0, the hint pins have no effect. When the hinted warp cannot compete, rotation picks the warp.
- R6: The rotation pointer moves only on an accepted rotation grant. A critical-first grant leaves it unchanged.
- R7: The grant is taken only when `fetch_vld` and `fetch_rdy` are both 1. Without `fetch_rdy`, the same warp stays offered and nothing else changes.
- R8: A fill for warp `w` sets the valid bit of the lowest-numbered empty slot of `w`, loads that slot's ready bit from `fill_rdy`, and ends the warp's in-flight fetch. A fill to a warp with no empty slot is ignored.
- R9: An issue event clears both the valid bit and the ready bit of the named slot. A fill in the same cycle to the same warp selects its slot from the state before the issue, so it never lands in the slot being issued.
- R10: At most one warp is offered per cycle, and `fetch_vld` is 0 when no warp can compete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_mode | input | 1 | 1 selects critical-first, 0 selects pure rotation |
| pred_vld | input | 1 | Issue-scheduler hint is present |
| pred_warp | input | WID_W | Warp expected to issue next cycle |
| issue_vld | input | 1 | An instruction leaves the buffer |
| issue_warp | input | WID_W | Warp of the issued instruction |
| issue_slot | input | SLOT_W | Slot of the issued instruction |
| fill_vld | input | 1 | A fetch response arrives |
| fill_warp | input | WID_W | Warp receiving the response |
| fill_rdy | input | 1 | Ready bit for the filled slot |
| fetch_vld | output | 1 | A warp is offered for fetch |
| fetch_warp | output | WID_W | Offered warp |
| fetch_rdy | input | 1 | Instruction cache accepts the offer |
| slot_valid | output | NUM_WARPS*SLOTS | Per-slot instruction-present bits |
| slot_ready | output | NUM_WARPS*SLOTS | Per-slot ready-to-execute bits |

## Verification
The bench builds the block with four warps and two slots per warp. With four warps, a full rotation and its wrap back to warp 0 take only a few grants, and the point where every warp is busy comes right after. With two slots, a third fill to the same warp reaches the full-buffer case. Two slots also give the case where a fill and an issue to the same warp in the same cycle must use different slots. Each scenario starts from reset, so the pointer position and the in-flight state that a check depends on are known exactly.

// File: rtl/wfa_pkg.sv
package wfa_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic {
    FETCH_ROTATE = 1'b0,
    FETCH_CRIT   = 1'b1
  } fetch_mode_e;

endpackage

// File: rtl/wfa_warp_slots.sv
module wfa_warp_slots #(
  parameter int SLOTS  = 2,
  parameter int SLOT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic              fill_rdy,
  input  logic              issue_en,
  input  logic [SLOT_W-1:0] issue_slot,
  input  logic              take,
  output logic [SLOTS-1:0]  vld_o,
  output logic [SLOTS-1:0]  rdy_o,
  output logic              pend_o,
  output logic              elig_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [SLOTS-1:0]  vld_q, rdy_q;
  logic              pend_q;
  logic              room;
  logic [SLOT_W-1:0] fill_idx;
  logic              issue_ok;

  // Find the lowest empty slot: scan from the top down so the last hit is the lowest.
  always_comb begin
    room     = 1'b0;
    fill_idx = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!vld_q[s]) begin
        room     = 1'b1;
        fill_idx = SLOT_W'(s);
      end
    end
  end

  assign issue_ok = issue_en && (int'(issue_slot) < SLOTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      rdy_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (issue_ok) begin
        vld_q[issue_slot] <= 1'b0;
        rdy_q[issue_slot] <= 1'b0;
      end
      if (fill_en && room) begin
        vld_q[fill_idx] <= 1'b1;
        rdy_q[fill_idx] <= fill_rdy;
      end
      if (fill_en && room) pend_q <= 1'b0;
      else if (take)       pend_q <= 1'b1;
    end
  end

  assign vld_o  = vld_q;
  assign rdy_o  = rdy_q;
  assign pend_o = pend_q;
  assign elig_o = ~|vld_q && !pend_q;

endmodule

// File: rtl/wfa_rr_pick.sv
module wfa_rr_pick #(
  parameter int N     = 8,
  parameter int WID_W = 3
) (
  input  logic [N-1:0]     elig,
  input  logic [WID_W-1:0] start,
  output logic             found,
  output logic [WID_W-1:0] idx
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = int'(start) + k;
      if (c >= N) c = c - N;
      if (!found && elig[c]) begin
        found = 1'b1;
        idx   = WID_W'(c);
      end
    end
  end

endmodule

// File: rtl/warp_fetch_arbiter.sv
module warp_fetch_arbiter
  import wfa_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int SLOTS     = 2,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BITS     = NUM_WARPS * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crit_mode,
  input  logic              pred_vld,
  input  logic [WID_W-1:0]  pred_warp,
  input  logic              issue_vld,
  input  logic [WID_W-1:0]  issue_warp,
  input  logic [SLOT_W-1:0] issue_slot,
  input  logic              fill_vld,
  input  logic [WID_W-1:0]  fill_warp,
  input  logic              fill_rdy,
  output logic              fetch_vld,
  output logic [WID_W-1:0]  fetch_warp,
  input  logic              fetch_rdy,
  output logic [BITS-1:0]   slot_valid,
  output logic [BITS-1:0]   slot_ready
);
  timeunit 1ns;
  timeprecision 1ps;

  fetch_mode_e            mode;
  logic [NUM_WARPS-1:0]   elig, pend, take_vec;
  logic [WID_W-1:0]       rr_ptr;
  logic                   rr_found;
  logic [WID_W-1:0]       rr_idx;
  logic                   crit_hit;
  logic                   accept;

  assign mode = fetch_mode_e'(crit_mode);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    wfa_warp_slots #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_en    (fill_vld && (fill_warp == WID_W'(w))),
      .fill_rdy   (fill_rdy),
      .issue_en   (issue_vld && (issue_warp == WID_W'(w))),
      .issue_slot (issue_slot),
      .take       (take_vec[w]),
      .vld_o      (slot_valid[w*SLOTS +: SLOTS]),
      .rdy_o      (slot_ready[w*SLOTS +: SLOTS]),
      .pend_o     (pend[w]),
      .elig_o     (elig[w])
    );
  end

  wfa_rr_pick #(.N(NUM_WARPS), .WID_W(WID_W)) u_rr (
    .elig  (elig),
    .start (rr_ptr),
    .found (rr_found),
    .idx   (rr_idx)
  );

  assign crit_hit = (mode == FETCH_CRIT) && pred_vld &&
                    (int'(pred_warp) < NUM_WARPS) && elig[pred_warp];

  assign fetch_vld  = crit_hit || rr_found;
  assign fetch_warp = crit_hit ? pred_warp : rr_idx;
  assign accept     = fetch_vld && fetch_rdy;

  always_comb begin
    take_vec = '0;
    if (accept) take_vec[fetch_warp] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (accept && !crit_hit) begin
      rr_ptr <= (int'(rr_idx) == NUM_WARPS - 1) ? '0 : rr_idx + 1'b1;
    end
  end

endmodule

// File: rtl/warp_fetch_arbiter_chk.sv
module warp_fetch_arbiter_chk #(
  parameter int NUM_WARPS = 8,
  parameter int SLOTS     = 2,
  parameter int WID_W     = 3,
  parameter int SLOT_W    = 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       crit_mode,
  input logic                       pred_vld,
  input logic [WID_W-1:0]           pred_warp,
  input logic                       issue_vld,
  input logic [WID_W-1:0]           issue_warp,
  input logic [SLOT_W-1:0]          issue_slot,
  input logic                       fill_vld,
  input logic [WID_W-1:0]           fill_warp,
  input logic                       fetch_vld,
  input logic [WID_W-1:0]           fetch_warp,
  input logic                       fetch_rdy,
  input logic [NUM_WARPS*SLOTS-1:0] slot_valid,
  input logic [NUM_WARPS-1:0]       pend,
  input logic [WID_W-1:0]           rr_ptr
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [SLOTS-1:0] v_of [NUM_WARPS];
  logic             all_busy;
  int               iss_bit;
  int               fill_cnt, fw_cnt;
  logic [WID_W-1:0] fw_q;

  always_comb begin
    all_busy = 1'b1;
    for (int w = 0; w < NUM_WARPS; w++) begin
      v_of[w] = slot_valid[w*SLOTS +: SLOTS];
      if (!(|v_of[w]) && !pend[w]) all_busy = 1'b0;
    end
  end

  assign iss_bit  = int'(issue_warp) * SLOTS + int'(issue_slot);
  assign fill_cnt = $countones(v_of[fill_warp]);
  assign fw_cnt   = $countones(v_of[fw_q]);

  always_ff @(posedge clk) fw_q <= fill_warp;

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |-> (v_of[fetch_warp] == '0) && !pend[fetch_warp]); // R2

  AST_CRIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_mode && pred_vld && v_of[pred_warp] == '0 && !pend[pred_warp])
      |-> (fetch_vld && fetch_warp == pred_warp)); // R4

  AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && fetch_rdy) |=> !(fetch_vld && fetch_warp == $past(fetch_warp))); // R2

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_vld && fetch_rdy) |=> $stable(rr_ptr)); // R7

  AST_IDLE_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    all_busy |-> !fetch_vld); // R10

  AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && int'(issue_slot) < SLOTS) |=> !slot_valid[$past(iss_bit)]); // R9

  AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && fill_cnt < SLOTS && !(issue_vld && issue_warp == fill_warp))
      |=> (fw_cnt == $past(fill_cnt) + 1)); // R8

endmodule

bind warp_fetch_arbiter warp_fetch_arbiter_chk #(
  .NUM_WARPS(NUM_WARPS), .SLOTS(SLOTS), .WID_W(WID_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .crit_mode  (crit_mode),
  .pred_vld   (pred_vld),
  .pred_warp  (pred_warp),
  .issue_vld  (issue_vld),
  .issue_warp (issue_warp),
  .issue_slot (issue_slot),
  .fill_vld   (fill_vld),
  .fill_warp  (fill_warp),
  .fetch_vld  (fetch_vld),
  .fetch_warp (fetch_warp),
  .fetch_rdy  (fetch_rdy),
  .slot_valid (slot_valid),
  .pend       (pend),
  .rr_ptr     (rr_ptr)
);

// File: tb/warp_fetch_arbiter_bench.sv
module warp_fetch_arbiter_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NW = 4;
  localparam int NS = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       crit_mode, pred_vld, issue_vld, fill_vld, fill_rdy, fetch_rdy;
  logic [1:0] pred_warp, issue_warp, fill_warp;
  logic [0:0] issue_slot;
  logic       fetch_vld;
  logic [1:0] fetch_warp;
  logic [7:0] slot_valid, slot_ready;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  warp_fetch_arbiter #(.NUM_WARPS(NW), .SLOTS(NS)) u_warp_fetch_arbiter (
    .clk(clk), .rst_n(rst_n), .crit_mode(crit_mode),
    .pred_vld(pred_vld), .pred_warp(pred_warp),
    .issue_vld(issue_vld), .issue_warp(issue_warp), .issue_slot(issue_slot),
    .fill_vld(fill_vld), .fill_warp(fill_warp), .fill_rdy(fill_rdy),
    .fetch_vld(fetch_vld), .fetch_warp(fetch_warp), .fetch_rdy(fetch_rdy),
    .slot_valid(slot_valid), .slot_ready(slot_ready)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    crit_mode = 0; pred_vld = 0; pred_warp = 0;
    issue_vld = 0; issue_warp = 0; issue_slot = 0;
    fill_vld = 0; fill_warp = 0; fill_rdy = 0; fetch_rdy = 0;
  endtask

  // one clock edge, then return at the falling edge plus settle time
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    step();
    step();
    rst_n = 1;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "slot_valid", 16'(slot_valid), 16'h0);
    chk("R1", "slot_ready", 16'(slot_ready), 16'h0);
    chk("R1", "offer valid", 16'(fetch_vld), 16'h1);
    chk("R1", "offer warp", 16'(fetch_warp), 16'h0);
  endtask

  task automatic t_rotation();
    do_reset();
    fetch_rdy = 1;
    for (int i = 0; i < NW; i++) begin
      #0;
      chk("R3", "rotation warp", 16'(fetch_warp), 16'(i));
      step();
    end
    chk("R10", "no offer when all in flight", 16'(fetch_vld), 16'h0);
    fetch_rdy = 0;
    fill_vld = 1; fill_warp = 2; fill_rdy = 1;
    step();
    fill_vld = 0;
    chk("R8", "fill ends in-flight, slot set", 16'(slot_valid), 16'h10);
    chk("R2", "filled warp not offered", 16'(fetch_vld), 16'h0);
    issue_vld = 1; issue_warp = 2; issue_slot = 0;
    step();
    issue_vld = 0;
    chk("R2", "emptied warp offered valid", 16'(fetch_vld), 16'h1);
    chk("R3", "emptied warp offered", 16'(fetch_warp), 16'h2);
  endtask

  task automatic t_fill_issue();
    do_reset();
    fill_vld = 1; fill_warp = 1; fill_rdy = 1;
    step();
    chk("R8", "first fill lowest slot", 16'(slot_valid), 16'h04);
    chk("R8", "first fill ready", 16'(slot_ready), 16'h04);
    fill_rdy = 0;
    step();
    chk("R8", "second fill next slot", 16'(slot_valid), 16'h0C);
    chk("R8", "second fill ready 0", 16'(slot_ready), 16'h04);
    fill_rdy = 1;
    step();
    chk("R8", "fill to full warp ignored valid", 16'(slot_valid), 16'h0C);
    chk("R8", "fill to full warp ignored ready", 16'(slot_ready), 16'h04);
    fill_warp = 0;
    step();
    fill_vld = 0;
    chk("R3", "rotation skips busy warps", 16'(fetch_warp), 16'h2);
    issue_vld = 1; issue_warp = 1; issue_slot = 1;
    step();
    chk("R9", "issue clears slot", 16'(slot_valid), 16'h05);
    chk("R9", "issue clears ready", 16'(slot_ready), 16'h05);
    issue_warp = 1; issue_slot = 0;
    fill_vld = 1; fill_warp = 1; fill_rdy = 0;
    step();
    issue_vld = 0; fill_vld = 0;
    chk("R9", "fill and issue same warp", 16'(slot_valid), 16'h09);
    chk("R9", "fill and issue same warp ready", 16'(slot_ready), 16'h01);
    issue_vld = 1; issue_warp = 0; issue_slot = 0;
    step();
    issue_vld = 0;
    chk("R2", "warp 0 empty again", 16'(fetch_warp), 16'h0);
  endtask

  task automatic t_backpressure();
    do_reset();
    fetch_rdy = 0;
    step();
    chk("R7", "offer held valid", 16'(fetch_vld), 16'h1);
    chk("R7", "offer held warp", 16'(fetch_warp), 16'h0);
    fetch_rdy = 1;
    step();
    chk("R7", "accepted then next", 16'(fetch_warp), 16'h1);
  endtask

  task automatic t_critical();
    do_reset();
    crit_mode = 1; pred_vld = 1; pred_warp = 2; fetch_rdy = 1;
    #0;
    chk("R4", "hinted warp first", 16'(fetch_warp), 16'h2);
    step();
    chk("R6", "pointer unchanged after hint grant", 16'(fetch_warp), 16'h0);
    chk("R5", "ineligible hint falls back", 16'(fetch_vld), 16'h1);
    step();
    chk("R3", "rotation continues", 16'(fetch_warp), 16'h1);
    pred_warp = 3;
    #0;
    chk("R4", "new hint wins", 16'(fetch_warp), 16'h3);
  endtask

  task automatic t_mode_off();
    do_reset();
    crit_mode = 0; pred_vld = 1; pred_warp = 3;
    #0;
    chk("R5", "hint ignored in rotation mode", 16'(fetch_warp), 16'h0);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    t_reset();
    t_rotation();
    t_fill_issue();
    t_backpressure();
    t_critical();
    t_mode_off();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule